// File: doc/BRIEF.md
# Dual-Accumulator Register Arithmetic Unit

This block is the single-cycle execute stage of a small 8-bit processor that has two accumulators. The accumulators, A and B, also act together as one 16-bit register D, with A as the upper byte and B as the lower byte. The block also holds two 16-bit index registers, X and Y, and two condition flags: carry (C) and signed overflow (V). An external decoder supplies a 5-bit operation code, an operand byte fetched from memory, and a valid strobe. On each clock edge where the strobe is high, the unit computes one result and writes it back to its registers.

The operation set has four groups:
- Arithmetic on one accumulator: add or subtract between A and B, add and subtract with the carry flag and the memory operand, increment, decrement, negate and complement.
- Shifts and rotates on either accumulator or on D. Rotates pass through the carry flag, so chained rotates extend a multiply or divide to wider words.
- An unsigned 8x8 multiply whose product fills D.
- Adding B to an index register, and swapping D with an index register.

Decode, divide, decimal adjust and the other condition flags are handled outside this block.

Top module: `dacc_exec`

## Requirements
- R1: While `rst_n` is low, and after it is released, all registers and both flags are zero until the first valid operation.
- R2: When `valid` is low, or when the code is 31 (idle), no register or flag changes.
- R3: Code 0 sets A to A+B and code 1 sets A to A-B, modulo 256. For both codes, C is the carry out (add) or the borrow (subtract), and V is set exactly when the signed result falls outside -128..127.
- R4: Codes 2 and 3 add `operand` plus C to A and to B respectively. Codes 4 and 5 subtract `operand` plus C from A and from B. C and V follow the rules of R3.
- R5: Codes 6 and 7 increment A and B. Codes 8 and 9 decrement A and B. C is unchanged. V is set when the result leaves the signed range: increment to 0x80, or decrement to 0x7F.
- R6: Codes 10 and 11 negate A and B (two's complement). After negate, C is 1 unless the result is 0, and V is 1 only when the result is 0x80. Codes 12 and 13 invert A and B bitwise, then set C to 1 and clear V.
- R7: Codes 14 to 23 act on A (even code) or B (odd code), in this order: shift left (codes 14/15), arithmetic shift right that keeps bit 7 (16/17), logical shift right (18/19), rotate left through carry (20/21), and rotate right through carry (22/23). The rotates insert the old C. C takes the bit moved out. V becomes the new bit 7 XOR the new C.
- R8: Code 24 shifts D left by one bit. Code 25 shifts D right logically by one bit. C takes the bit moved out. V becomes the new bit 15 XOR the new C. Both A and B reflect the new D.
- R9: Code 26 writes the unsigned product A*B into D, with A as the high byte. C becomes bit 7 of the product. V is unchanged.
- R10: Code 27 adds B, zero-extended, to X modulo 65536. Code 28 does the same to Y. A, B and both flags are unchanged.
- R11: Code 29 swaps D with X in one step. Code 30 swaps D with Y in one step. Flags are unchanged.
- R12: Codes 0 to 23 leave X, Y and the accumulator they do not target unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| valid | input | 1 | Execute the operation on this clock edge |
| op_code | input | 5 | Operation select, encoded as listed in the requirements |
| operand | input | W | Memory operand byte used by the carry-in codes |
| acc_a | output | W | Accumulator A, the high byte of D |
| acc_b | output | W | Accumulator B, the low byte of D |
| idx_x | output | 2W | Index register X |
| idx_y | output | 2W | Index register Y |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench builds the unit with the default accumulator width of 8, so D and the index registers are 16 bits wide. At this width, a few thousand random operations with random operands regularly reach the signed boundaries 0x7F and 0x80, a zero result from negate, the largest product 0xFE01, and index additions that wrap past 0xFFFF. The bench loads accumulator values through the carry-in add codes, which checks R4 as a side effect of setting up every directed corner case.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  localparam int OP_BITS = 5;

  typedef enum logic [OP_BITS-1:0] {
    OP_ACC_ADD  = 5'd0,
    OP_ACC_SUB  = 5'd1,
    OP_ADDC_A   = 5'd2,
    OP_ADDC_B   = 5'd3,
    OP_SUBC_A   = 5'd4,
    OP_SUBC_B   = 5'd5,
    OP_INC_A    = 5'd6,
    OP_INC_B    = 5'd7,
    OP_DEC_A    = 5'd8,
    OP_DEC_B    = 5'd9,
    OP_NEG_A    = 5'd10,
    OP_NEG_B    = 5'd11,
    OP_INV_A    = 5'd12,
    OP_INV_B    = 5'd13,
    OP_SHL_A    = 5'd14,
    OP_SHL_B    = 5'd15,
    OP_SAR_A    = 5'd16,
    OP_SAR_B    = 5'd17,
    OP_SHR_A    = 5'd18,
    OP_SHR_B    = 5'd19,
    OP_RCL_A    = 5'd20,
    OP_RCL_B    = 5'd21,
    OP_RCR_A    = 5'd22,
    OP_RCR_B    = 5'd23,
    OP_SHL_D    = 5'd24,
    OP_SHR_D    = 5'd25,
    OP_MUL_AB   = 5'd26,
    OP_X_ADD_B  = 5'd27,
    OP_Y_ADD_B  = 5'd28,
    OP_SWAP_DX  = 5'd29,
    OP_SWAP_DY  = 5'd30,
    OP_IDLE     = 5'd31
  } op_e;
endpackage

// File: rtl/dacc_alu8.sv
module dacc_alu8
  import dacc_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  input  logic         cin,
  input  logic         vin,
  output logic [W-1:0] a_nx,
  output logic [W-1:0] b_nx,
  output logic         c_nx,
  output logic         v_nx
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  logic         to_b;
  logic [W-1:0] x, y, res;
  logic [W:0]   wide;
  logic         ci;

  // target accumulator: odd codes in the single-accumulator group go to B
  always_comb begin
    case (op)
      OP_ADDC_B, OP_SUBC_B, OP_INC_B, OP_DEC_B, OP_NEG_B, OP_INV_B,
      OP_SHL_B, OP_SAR_B, OP_SHR_B, OP_RCL_B, OP_RCR_B: to_b = 1'b1;
      default:                                          to_b = 1'b0;
    endcase
  end

  always_comb begin
    x    = to_b ? b : a;
    y    = (op == OP_ACC_ADD || op == OP_ACC_SUB) ? b : m;
    ci   = (op == OP_ACC_ADD || op == OP_ACC_SUB) ? 1'b0 : cin;
    res  = x;
    c_nx = cin;
    v_nx = vin;
    wide = '0;
    case (op)
      OP_ACC_ADD, OP_ADDC_A, OP_ADDC_B: begin
        wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        res  = wide[MSB:0];
        c_nx = wide[W];
        v_nx = (x[MSB] == y[MSB]) && (res[MSB] != x[MSB]);
      end
      OP_ACC_SUB, OP_SUBC_A, OP_SUBC_B: begin
        wide = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, ci};
        res  = wide[MSB:0];
        c_nx = wide[W];
        v_nx = (x[MSB] != y[MSB]) && (res[MSB] != x[MSB]);
      end
      OP_INC_A, OP_INC_B: begin
        res  = x + 1'b1;
        v_nx = (res == MIN_NEG);
      end
      OP_DEC_A, OP_DEC_B: begin
        res  = x - 1'b1;
        v_nx = (res == MAX_POS);
      end
      OP_NEG_A, OP_NEG_B: begin
        res  = '0 - x;
        c_nx = |res;
        v_nx = (res == MIN_NEG);
      end
      OP_INV_A, OP_INV_B: begin
        res  = ~x;
        c_nx = 1'b1;
        v_nx = 1'b0;
      end
      OP_SHL_A, OP_SHL_B: begin
        res  = {x[MSB-1:0], 1'b0};
        c_nx = x[MSB];
        v_nx = res[MSB] ^ x[MSB];
      end
      OP_SAR_A, OP_SAR_B: begin
        res  = {x[MSB], x[MSB:1]};
        c_nx = x[0];
        v_nx = res[MSB] ^ x[0];
      end
      OP_SHR_A, OP_SHR_B: begin
        res  = {1'b0, x[MSB:1]};
        c_nx = x[0];
        v_nx = x[0];
      end
      OP_RCL_A, OP_RCL_B: begin
        res  = {x[MSB-1:0], cin};
        c_nx = x[MSB];
        v_nx = res[MSB] ^ x[MSB];
      end
      OP_RCR_A, OP_RCR_B: begin
        res  = {cin, x[MSB:1]};
        c_nx = x[0];
        v_nx = cin ^ x[0];
      end
      default: ;
    endcase
    a_nx = to_b ? a : res;
    b_nx = to_b ? res : b;
  end
endmodule

// File: rtl/dacc_wide.sv
module dacc_wide
  import dacc_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e            op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [2*W-1:0] ix,
  input  logic [2*W-1:0] iy,
  input  logic           cin,
  input  logic           vin,
  output logic [2*W-1:0] d_nx,
  output logic [2*W-1:0] x_nx,
  output logic [2*W-1:0] y_nx,
  output logic           c_nx,
  output logic           v_nx
);
  localparam int DW = 2 * W;

  logic [DW-1:0] d, b_ext, prod;

  assign d     = {a, b};
  assign b_ext = {{W{1'b0}}, b};
  assign prod  = {{W{1'b0}}, a} * b_ext;

  always_comb begin
    d_nx = d;
    x_nx = ix;
    y_nx = iy;
    c_nx = cin;
    v_nx = vin;
    case (op)
      OP_SHL_D: begin
        d_nx = {d[DW-2:0], 1'b0};
        c_nx = d[DW-1];
        v_nx = d[DW-2] ^ d[DW-1];
      end
      OP_SHR_D: begin
        d_nx = {1'b0, d[DW-1:1]};
        c_nx = d[0];
        v_nx = d[0];
      end
      OP_MUL_AB: begin
        d_nx = prod;
        c_nx = prod[W-1];
      end
      OP_X_ADD_B: x_nx = ix + b_ext;
      OP_Y_ADD_B: y_nx = iy + b_ext;
      OP_SWAP_DX: begin
        d_nx = ix;
        x_nx = d;
      end
      OP_SWAP_DY: begin
        d_nx = iy;
        y_nx = d;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dacc_exec.sv
module dacc_exec
  import dacc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid,
  input  logic [4:0]     op_code,
  input  logic [W-1:0]   operand,
  output logic [W-1:0]   acc_a,
  output logic [W-1:0]   acc_b,
  output logic [2*W-1:0] idx_x,
  output logic [2*W-1:0] idx_y,
  output logic           flag_c,
  output logic           flag_v
);
  localparam int DW = 2 * W;

  op_e op;
  assign op = op_e'(op_code);

  // reset asserts at once, releases two edges later
  logic [1:0] rst_pipe;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  logic [W-1:0]  a_q, b_q, a_n, b_n;
  logic [DW-1:0] x_q, y_q, x_n, y_n;
  logic          c_q, v_q, c_n, v_n;

  logic [W-1:0]  alu_a, alu_b;
  logic          alu_c, alu_v;
  logic [DW-1:0] wd_d, wd_x, wd_y;
  logic          wd_c, wd_v;

  dacc_alu8 #(.W(W)) u_alu8 (
    .op(op), .a(a_q), .b(b_q), .m(operand), .cin(c_q), .vin(v_q),
    .a_nx(alu_a), .b_nx(alu_b), .c_nx(alu_c), .v_nx(alu_v)
  );

  dacc_wide #(.W(W)) u_wide (
    .op(op), .a(a_q), .b(b_q), .ix(x_q), .iy(y_q), .cin(c_q), .vin(v_q),
    .d_nx(wd_d), .x_nx(wd_x), .y_nx(wd_y), .c_nx(wd_c), .v_nx(wd_v)
  );

  always_comb begin
    if (op <= OP_RCR_B) begin
      a_n = alu_a;
      b_n = alu_b;
      x_n = x_q;
      y_n = y_q;
      c_n = alu_c;
      v_n = alu_v;
    end else begin
      {a_n, b_n} = wd_d;
      x_n = wd_x;
      y_n = wd_y;
      c_n = wd_c;
      v_n = wd_v;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      a_q <= '0;
      b_q <= '0;
      x_q <= '0;
      y_q <= '0;
      c_q <= 1'b0;
      v_q <= 1'b0;
    end else if (valid) begin
      a_q <= a_n;
      b_q <= b_n;
      x_q <= x_n;
      y_q <= y_n;
      c_q <= c_n;
      v_q <= v_n;
    end
  end

  assign acc_a  = a_q;
  assign acc_b  = b_q;
  assign idx_x  = x_q;
  assign idx_y  = y_q;
  assign flag_c = c_q;
  assign flag_v = v_q;

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (!valid || op == OP_IDLE) |=> $stable({a_q, b_q, x_q, y_q, c_q, v_q}));

  assert_incdec_carry_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (valid && op inside {OP_INC_A, OP_INC_B, OP_DEC_A, OP_DEC_B}) |=> $stable(c_q));

  assert_invert_flags_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (valid && op inside {OP_INV_A, OP_INV_B}) |=> (c_q && !v_q));

  assert_mul_product_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (valid && op == OP_MUL_AB) |=>
      ({a_q, b_q} == {{W{1'b0}}, $past(a_q)} * {{W{1'b0}}, $past(b_q)}) && $stable(v_q));

  assert_index_add_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (valid && op == OP_X_ADD_B) |=>
      (x_q == $past(x_q) + {{W{1'b0}}, $past(b_q)}) && $stable({a_q, b_q, c_q, v_q}));

  assert_swap_dx_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    (valid && op == OP_SWAP_DX) |=>
      (x_q == {$past(a_q), $past(b_q)}) && ({a_q, b_q} == $past(x_q)));

  assert_index_kept_R12: assert property (@(posedge clk) disable iff (!rst_ok)
    (valid && op <= OP_RCR_B) |=> $stable({x_q, y_q}));
endmodule

// File: tb/tb_dacc_exec.sv
module tb_dacc_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [4:0]  op_code = 5'd31;
  logic [7:0]  operand = 8'd0;
  logic [7:0]  acc_a, acc_b;
  logic [15:0] idx_x, idx_y;
  logic        flag_c, flag_v;

  always #5 clk = ~clk;

  dacc_exec #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op_code(op_code), .operand(operand),
    .acc_a(acc_a), .acc_b(acc_b), .idx_x(idx_x), .idx_y(idx_y),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] x;
    logic [15:0] y;
    logic        c;
    logic        v;
  } st_t;

  typedef struct {
    st_t   exp;
    string tag;
  } item_t;

  item_t q[$];
  st_t   sh;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  function automatic int sg(logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  function automatic string tag_of(logic [4:0] o, logic vld);
    if (!vld || o == 5'd31) return "R2";
    if (o <= 5'd1)  return "R3,R12";
    if (o <= 5'd5)  return "R4,R12";
    if (o <= 5'd9)  return "R5,R12";
    if (o <= 5'd13) return "R6,R12";
    if (o <= 5'd23) return "R7,R12";
    if (o <= 5'd25) return "R8";
    if (o == 5'd26) return "R9";
    if (o <= 5'd28) return "R10";
    return "R11";
  endfunction

  // reference model written from the requirements
  function automatic st_t model(st_t s, logic [4:0] o, logic [7:0] m, logic vld);
    st_t n = s;
    int  t, r, ci, d, sr;
    bit  on_b;
    if (!vld || o == 5'd31) return n;
    if (o <= 5'd23) begin
      on_b = (o >= 5'd2) && o[0];
      t  = on_b ? int'(s.b) : int'(s.a);
      ci = s.c ? 1 : 0;
      r  = t;
      case (o)
        5'd0, 5'd2, 5'd3: begin
          int y = (o == 5'd0) ? int'(s.b) : int'(m);
          int c2 = (o == 5'd0) ? 0 : ci;
          r = t + y + c2;
          sr = sg(8'(t)) + sg(8'(y)) + c2;
          n.c = (r > 255);
          n.v = (sr > 127) || (sr < -128);
          r = r % 256;
        end
        5'd1, 5'd4, 5'd5: begin
          int y = (o == 5'd1) ? int'(s.b) : int'(m);
          int c2 = (o == 5'd1) ? 0 : ci;
          r = t - y - c2;
          sr = sg(8'(t)) - sg(8'(y)) - c2;
          n.c = (r < 0);
          n.v = (sr > 127) || (sr < -128);
          r = (r + 512) % 256;
        end
        5'd6, 5'd7: begin r = (t + 1) % 256; n.v = (t == 127); end
        5'd8, 5'd9: begin r = (t + 255) % 256; n.v = (t == 128); end
        5'd10, 5'd11: begin r = (256 - t) % 256; n.c = (t != 0); n.v = (t == 128); end
        5'd12, 5'd13: begin r = 255 - t; n.c = 1'b1; n.v = 1'b0; end
        5'd14, 5'd15: begin r = (t * 2) % 256; n.c = (t >= 128); end
        5'd16, 5'd17: begin r = t / 2 + ((t >= 128) ? 128 : 0); n.c = (t % 2 == 1); end
        5'd18, 5'd19: begin r = t / 2; n.c = (t % 2 == 1); end
        5'd20, 5'd21: begin r = (t * 2) % 256 + ci; n.c = (t >= 128); end
        default:      begin r = t / 2 + ci * 128; n.c = (t % 2 == 1); end
      endcase
      if (o >= 5'd14) n.v = (r >= 128) ^ n.c;
      if (on_b) n.b = 8'(r); else n.a = 8'(r);
    end else begin
      d = int'(s.a) * 256 + int'(s.b);
      case (o)
        5'd24: begin r = (d * 2) % 65536; n.c = (d >= 32768); n.v = (r >= 32768) ^ n.c; end
        5'd25: begin r = d / 2; n.c = (d % 2 == 1); n.v = n.c; end
        5'd26: begin r = int'(s.a) * int'(s.b); n.c = ((r / 128) % 2 == 1); end
        5'd27: begin r = d; n.x = 16'((int'(s.x) + int'(s.b)) % 65536); end
        5'd28: begin r = d; n.y = 16'((int'(s.y) + int'(s.b)) % 65536); end
        5'd29: begin r = int'(s.x); n.x = 16'(d); end
        default: begin r = int'(s.y); n.y = 16'(d); end
      endcase
      n.a = 8'(r / 256);
      n.b = 8'(r % 256);
    end
    return n;
  endfunction

  task automatic step(logic [4:0] o, logic [7:0] m, logic vld);
    item_t it;
    @(negedge clk);
    valid   = vld;
    op_code = o;
    operand = m;
    sh      = model(sh, o, m, vld);
    it.exp  = sh;
    it.tag  = tag_of(o, vld);
    q.push_back(it);
  endtask

  // load accumulators through the carry-in add codes (R4)
  task automatic load_a(logic [7:0] v);
    step(5'd2, 8'(int'(v) - int'(sh.a) - (sh.c ? 1 : 0)), 1'b1);
  endtask

  task automatic load_b(logic [7:0] v);
    step(5'd3, 8'(int'(v) - int'(sh.b) - (sh.c ? 1 : 0)), 1'b1);
  endtask

  // monitor: compare one expected item per clock edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      st_t   got;
      it  = q.pop_front();
      got = '{a: acc_a, b: acc_b, x: idx_x, y: idx_y, c: flag_c, v: flag_v};
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s: got a=%h b=%h x=%h y=%h c=%b v=%b expected a=%h b=%h x=%h y=%h c=%b v=%b",
                 it.tag, got.a, got.b, got.x, got.y, got.c, got.v,
                 it.exp.a, it.exp.b, it.exp.x, it.exp.y, it.exp.c, it.exp.v);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    sh = '0;
    repeat (3) @(negedge clk);
    checks++;
    if ({acc_a, acc_b, idx_x, idx_y, flag_c, flag_v} !== 50'd0) begin
      errors++;
      $display("FAIL R1: got %h expected 0", {acc_a, acc_b, idx_x, idx_y, flag_c, flag_v});
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if ({acc_a, acc_b, idx_x, idx_y, flag_c, flag_v} !== 50'd0) begin
      errors++;
      $display("FAIL R1: got %h expected 0 after release", {acc_a, acc_b, idx_x, idx_y, flag_c, flag_v});
    end

    // R3 signed overflow on add, borrow on subtract
    load_a(8'h7F); load_b(8'h01); step(5'd0, 8'h00, 1'b1);
    load_a(8'h00); step(5'd1, 8'h00, 1'b1);
    // R4 subtract with carry in
    step(5'd4, 8'h10, 1'b1);
    // R6 negate of 0x80 and of zero, invert
    load_a(8'h80); step(5'd10, 8'h00, 1'b1);
    load_a(8'h00); step(5'd10, 8'h00, 1'b1);
    step(5'd13, 8'h00, 1'b1);
    // R5 increment wrap keeps carry
    step(5'd12, 8'h00, 1'b1); step(5'd6, 8'h00, 1'b1);
    load_a(8'h80); step(5'd8, 8'h00, 1'b1);
    // R7 shifts and rotates on B
    load_b(8'h81); step(5'd17, 8'h00, 1'b1); step(5'd23, 8'h00, 1'b1);
    step(5'd21, 8'h00, 1'b1); step(5'd19, 8'h00, 1'b1); step(5'd15, 8'h00, 1'b1);
    // R9 largest product
    load_a(8'hFF); load_b(8'hFF); step(5'd26, 8'h00, 1'b1);
    // R11 swaps, R10 index add with wrap
    step(5'd29, 8'h00, 1'b1); load_a(8'hFF); load_b(8'hFF); step(5'd30, 8'h00, 1'b1);
    load_b(8'hFF); step(5'd27, 8'h00, 1'b1); step(5'd28, 8'h00, 1'b1);
    // R8 wide shifts
    load_a(8'hC0); load_b(8'h01); step(5'd24, 8'h00, 1'b1); step(5'd25, 8'h00, 1'b1);
    // R2 strobe low and idle code
    step(5'd0, 8'h55, 1'b0); step(5'd31, 8'hAA, 1'b1);

    // random operations, all codes
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] o;
      logic [7:0] m;
      o = 5'($urandom_range(0, 31));
      m = 8'($urandom);
      step(o, m, ($urandom_range(0, 9) != 0));
    end

    @(negedge clk);
    valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule